// File: doc/BRIEF.md
# Memory Area Secure-Partition Checker

This block guards a set of on-chip memory zones, each divided at one page-granular boundary. Every zone has a lower secure partition that starts at the zone's base address and covers a configurable number of 4 KB pages. The remainder of the zone, from that boundary up to its top, is open to nonsecure masters.

Each zone has one 32-bit configuration word on a simple register port. The word holds the partition size in pages and a sticky lock bit. Each zone also has its own access checker. The checker takes the byte offset of an access within the zone and the access's secure flag, and it returns grant or deny in the same cycle.

There is no separate treatment of reads and writes. An access is either secure or nonsecure, and that alone sets the rule that applies to it.

Top module: `msp_top`

## Requirements
- R1: After reset, every zone's size field holds the parameter `DEF_SIZE` and every lock bit reads 0.
- R2: Zone k's word sits at byte address 4*k on the register port. Reads return the lock in bit 31 and the size in bits 9:0, with all other bits 0. A write to one zone leaves every other zone unchanged.
- R3: A write to an unlocked zone loads bits 9:0 into its size and bit 31 into its lock. Both are visible on the next clock.
- R4: While a zone's lock bit is 1, writes to it have no effect on either size or lock until the next reset.
- R5: A secure access is always granted, whatever the size.
- R6: A nonsecure access at offset `off` is granted exactly when `off >> 12` is greater than or equal to the zone's size. Otherwise it is denied.
- R7: A size of 0 opens the whole zone to nonsecure accesses. A size equal to or larger than the zone's page count denies every nonsecure access in the zone.
- R8: A port address that does not map to a zone changes nothing on write and reads 0. Such an address is one with bits 1:0 nonzero or with an index of `NUM_ZONES` or more.
- R9: The grant outputs follow the register state without delay, so a new size governs accesses from the clock after its write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_addr | input | ADDR_W | Byte address on the register port |
| cfg_we | input | 1 | Write strobe for the register port |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for `cfg_addr` (combinational) |
| acc_off | input | NUM_ZONES*OFF_W | Access byte offset for each zone, zone k in slice k |
| acc_sec | input | NUM_ZONES | Secure flag of each zone's access |
| acc_grant | output | NUM_ZONES | 1 grants the access of that zone, 0 denies it |

## Verification
A corrupted size register shows on the grant outputs of its zone at once. Nonsecure accesses near the boundary page flip between grant and deny in the cycle the register goes wrong, and register readback exposes the same fault at once. The bench therefore sweeps every page of a small zone, at both page edges, for boundary values of 0, 1, mid-range, the page count minus one, the page count and the field maximum. This catches off-by-one comparisons and truncated widths. A lock that fails to hold, or that clears, shows on the first rejected write that follows.

// File: rtl/msp_pkg.sv
package msp_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned LOCK_POS   = 31;
  localparam int unsigned PAGE_SHIFT = 12;

  // Assemble a readback word from a lock flag and a zero-extended low field
  function automatic logic [WORD_W-1:0] pack_word(input logic lock,
                                                  input logic [LOCK_POS-1:0] low);
    return {lock, low};
  endfunction
endpackage

// File: rtl/msp_zone_reg.sv
module msp_zone_reg #(
  parameter int unsigned SIZE_W   = 10,
  parameter int unsigned DEF_SIZE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SIZE_W-1:0] wr_size,
  input  logic              wr_lock,
  output logic [SIZE_W-1:0] size_q,
  output logic              lock_q
);
  logic [SIZE_W-1:0] size_d;
  logic              lock_d;
  logic              upd_en;

  always_comb begin
    upd_en = wr_en && !lock_q;
    size_d = size_q;
    lock_d = lock_q;
    if (upd_en) begin
      size_d = wr_size;
      lock_d = wr_lock;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= SIZE_W'(DEF_SIZE);
      lock_q <= 1'b0;
    end else if (upd_en) begin
      size_q <= size_d;
      lock_q <= lock_d;
    end
  end

  // R4: a set lock freezes the zone and never clears by itself
  a_r4_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> (lock_q && $stable(size_q)));

  // R3: an accepted write is visible on the next clock
  a_r3_write_take: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !lock_q) |=> (size_q == $past(wr_size) && lock_q == $past(wr_lock)));
endmodule

// File: rtl/msp_zone_check.sv
module msp_zone_check #(
  parameter int unsigned SIZE_W = 10,
  parameter int unsigned OFF_W  = 16
) (
  input  logic [SIZE_W-1:0] size,
  input  logic [OFF_W-1:0]  off,
  input  logic              sec,
  output logic              grant
);
  import msp_pkg::*;
  localparam int unsigned PG_W         = OFF_W - PAGE_SHIFT;
  localparam int unsigned REGION_PAGES = 1 << PG_W;
  localparam int unsigned CMP_W        = ((SIZE_W > PG_W) ? SIZE_W : PG_W) + 1;

  logic [PG_W-1:0]  page;
  logic [CMP_W-1:0] page_x, size_x;

  always_comb begin
    page   = off[OFF_W-1:PAGE_SHIFT];
    page_x = CMP_W'(page);
    size_x = CMP_W'(size);
    grant  = sec || (page_x >= size_x);
  end

  always_comb begin
    if (!$isunknown({size, sec})) begin
      // R5: secure masters are never blocked
      a_r5_secure_grant: assert (!sec || grant);
      // R7: a boundary at or past the top closes the zone to nonsecure traffic
      a_r7_full_secure: assert (!(!sec && (32'(size) >= REGION_PAGES) && grant));
    end
  end
endmodule

// File: rtl/msp_top.sv
module msp_top #(
  parameter int unsigned NUM_ZONES = 2,
  parameter int unsigned SIZE_W    = 10,
  parameter int unsigned OFF_W     = 16,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DEF_SIZE  = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [ADDR_W-1:0]              cfg_addr,
  input  logic                           cfg_we,
  input  logic [31:0]                    cfg_wdata,
  output logic [31:0]                    cfg_rdata,
  input  logic [NUM_ZONES*OFF_W-1:0]     acc_off,
  input  logic [NUM_ZONES-1:0]           acc_sec,
  output logic [NUM_ZONES-1:0]           acc_grant
);
  import msp_pkg::*;
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [IDX_W-1:0]  idx;
  logic              hit;
  logic [NUM_ZONES-1:0] zone_we;
  logic [SIZE_W-1:0] zone_size [NUM_ZONES];
  logic [NUM_ZONES-1:0] zone_lock;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  always_comb begin
    idx = cfg_addr[ADDR_W-1:2];
    hit = (cfg_addr[1:0] == 2'b00) && (32'(idx) < NUM_ZONES);
  end

  for (genvar k = 0; k < NUM_ZONES; k++) begin : g_zone
    assign zone_we[k] = cfg_we && hit && (idx == IDX_W'(k));

    msp_zone_reg #(.SIZE_W(SIZE_W), .DEF_SIZE(DEF_SIZE)) u_reg (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr_en   (zone_we[k]),
      .wr_size (cfg_wdata[SIZE_W-1:0]),
      .wr_lock (cfg_wdata[LOCK_POS]),
      .size_q  (zone_size[k]),
      .lock_q  (zone_lock[k])
    );

    msp_zone_check #(.SIZE_W(SIZE_W), .OFF_W(OFF_W)) u_chk (
      .size  (zone_size[k]),
      .off   (acc_off[k*OFF_W +: OFF_W]),
      .sec   (acc_sec[k]),
      .grant (acc_grant[k])
    );

    // R2: writes aimed elsewhere leave this zone alone
    a_r2_other_zone_stable: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (cfg_we && !zone_we[k]) |=> ($stable(zone_size[k]) && $stable(zone_lock[k])));
  end

  always_comb begin
    cfg_rdata = '0;
    for (int k = 0; k < NUM_ZONES; k++) begin
      if (hit && idx == IDX_W'(k))
        cfg_rdata = pack_word(zone_lock[k], LOCK_POS'(zone_size[k]));
    end
  end

  // R8: unmapped addresses read as zero
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !hit |-> (cfg_rdata == 32'h0));
endmodule

// File: tb/msp_top_tb.sv
module msp_top_tb;
  localparam int NZ = 2, SW = 10, OW = 16, AW = 8, DEF = 4;
  localparam int PAGES = 1 << (OW - 12);

  logic clk = 1'b0, rst_n = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic [NZ*OW-1:0] acc_off = '0;
  logic [NZ-1:0] acc_sec = '0, acc_grant;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int zsize [NZ];

  always #4 clk = ~clk;

  msp_top #(.NUM_ZONES(NZ), .SIZE_W(SW), .OFF_W(OW), .ADDR_W(AW), .DEF_SIZE(DEF)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_addr(cfg_addr), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .acc_off(acc_off), .acc_sec(acc_sec), .acc_grant(acc_grant));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_addr = a; cfg_wdata = d; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a;
    #1 chk(req, cfg_rdata, exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int z = 0; z < NZ; z++) zsize[z] = DEF;
  endtask

  // sweep every page at both edges, both secure flags, on zone z
  task automatic sweep(input string req, input int z);
    for (int p = 0; p < PAGES; p++) begin
      for (int e = 0; e < 2; e++) begin
        for (int s = 0; s < 2; s++) begin
          logic [OW-1:0] off;
          off = OW'(p * 4096 + e * 4095);
          @(negedge clk);
          acc_off[z*OW +: OW] = off;
          acc_sec[z] = s[0];
          #1 chk(req, 32'(acc_grant[z]), 32'((s == 1) || ((int'(off) >> 12) >= zsize[z])));
        end
      end
    end
  endtask

  initial begin
    int sizes [7] = '{0, 1, 7, 15, 16, 20, 1023};
    do_reset();
    // R1: reset defaults
    rd("R1", 8'h00, 32'(DEF));
    rd("R1", 8'h04, 32'(DEF));
    sweep("R1/R6", 0);
    // R2/R3: per-zone write, field placement
    wr(8'h04, 32'h0000_0009); zsize[1] = 9;
    rd("R2", 8'h00, 32'(DEF));
    rd("R3", 8'h04, 32'h9);
    wr(8'h04, 32'h7FFF_FC0A); zsize[1] = 10;
    rd("R2", 8'h04, 32'h0000_000A);
    // R5/R6/R7/R9: boundary sweep on zone 0, zone 1 unaffected
    foreach (sizes[i]) begin
      wr(8'h00, 32'(sizes[i])); zsize[0] = sizes[i];
      sweep("R6/R7/R9", 0);
      sweep("R2/R5", 1);
    end
    // R8: unmapped and misaligned writes
    wr(8'h00, 32'h0000_0005); zsize[0] = 5;
    wr(8'h08, 32'h0000_0001);
    wr(8'h01, 32'h0000_0002);
    wr(8'hFC, 32'h8000_0003);
    rd("R8", 8'h00, 32'h5);
    rd("R8", 8'h04, 32'hA);
    rd("R8", 8'h08, 32'h0);
    rd("R8", 8'h01, 32'h0);
    // R4: lock freezes zone 0 only
    wr(8'h00, 32'h8000_0003); zsize[0] = 3;
    rd("R3", 8'h00, 32'h8000_0003);
    wr(8'h00, 32'h0000_0007);
    rd("R4", 8'h00, 32'h8000_0003);
    wr(8'h00, 32'h8000_000C);
    rd("R4", 8'h00, 32'h8000_0003);
    sweep("R4", 0);
    wr(8'h04, 32'h0000_0002); zsize[1] = 2;
    rd("R4", 8'h04, 32'h2);
    sweep("R4", 1);
    do_reset();
    rd("R4", 8'h00, 32'(DEF));
    wr(8'h00, 32'h0000_0008);
    rd("R4", 8'h00, 32'h8);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule